// File: doc/BRIEF.md
# Prefetch and ECC Control Register Bank

This block is the control and status register bank that sits beside a memory controller's prefetch engine and its bank of parity accumulators. A host reads and writes 32-bit words through a simple word-addressed port. Writes commit on the clock edge. Reads return data combinationally from the current address. The bank holds the interrupt status and enable registers and drives a level interrupt from them. It also keeps the prefetch configuration, starts the prefetch engine and reports the FIFO level, a threshold flag and the engine's transfer count in one status word.

On the parity side, the bank keeps the accumulator pointer, the enable and the size settings. It issues a single-cycle clear strobe to all accumulators and passes their results back to the host as read-only words. A write with the soft-reset bit set returns the whole bank to its reset values. A write to an address outside the map raises a one-cycle error flag.

Top module: `pe_regbank`

## Requirements
- R1: `irq_o` is high exactly when some bit is set in both the interrupt status register (word 3) and the interrupt enable register (word 4). A write to the enable register stores only the bits under mask 0xF03.
- R2: A high bit of `irq_evt_i` under mask 0xF03 sets the matching status bit. Writing 1 to a status bit clears it, and an event in the same cycle wins over the clear. `irq_o` follows the status register in the cycle after the write edge.
- R3: Writing the system configuration register (word 1) with bit 1 set returns every register of the bank to its reset value. The register then stores only the written bits under mask 0x19.
- R4: Writing the prefetch control register (word 7) with bit 0 set starts the engine and loads the FIFO level. The level becomes 64 if bit 0 of prefetch config 1 is set, and 0 otherwise. Writing bit 0 as 0 stops the engine and leaves the level unchanged. Word 7 reads back the run bit in bit 0.
- R5: The prefetch status word (word 8) carries the FIFO level in bits 31:24. Bit 16 is set only when the level is strictly greater than the threshold in bits 14:8 of prefetch config 1. Bits 13:0 hold `pf_count_i`. All other bits read 0.
- R6: Prefetch config 1 (word 5) resets to 0x00004000 and stores writes under mask 0x7F8F7FBF. Prefetch config 2 (word 6) resets to 0 and keeps the low 14 bits.
- R7: A write to the parity control register (word 10) with bit 8 set drives `ecc_clr_o` high for exactly the one cycle after the write edge. A soft reset does the same.
- R8: A write to word 10 loads the pointer from bits 3:0. A value of 0 or above 9 sets the pointer to 0 and clears bit 0 (the enable) of the parity config register. Word 10 reads back the pointer.
- R9: The parity size register (word 11) resets to 0x3FCFF000 and stores writes under mask 0x3FCFF1FF. The parity config register (word 9) resets to 0 and stores writes under mask 0x8F. `ecc_en_o` reflects its bit 0 and `ecc_ptr_o` the pointer.
- R10: The identity word (word 0, reads 0x00000031), the system status word (word 2, reads 1), the prefetch status and the parity results ignore writes and raise no error.
- R11: Words 12 to 20 read parity result k, taken from bits 32k+31:32k of `ecc_res_i` at word 12+k. Reads of addresses 21 to 31 return 0. A write to addresses 21 to 31 drives `err_o` high for one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| err_o | output | 1 | One-cycle flag for a write to an unmapped address |
| irq_evt_i | input | 12 | Interrupt event pulses |
| irq_o | output | 1 | Interrupt request |
| pf_count_i | input | 14 | Transfer count from the prefetch engine |
| pf_run_o | output | 1 | Prefetch engine run bit |
| ecc_res_i | input | 288 | Nine 32-bit accumulator results |
| ecc_clr_o | output | 1 | Single-cycle clear to all accumulators |
| ecc_ptr_o | output | 4 | Accumulator pointer |
| ecc_en_o | output | 1 | Parity accumulation enable |

## Verification
A corrupted status or enable bit is visible on `irq_o` one edge after it happens, and on the next read of word 3 or 4. A wrong FIFO level or threshold compare shows up in the next read of word 8 after a start write. A pointer that escapes the legal range, or a clear strobe that sticks, shows on `ecc_ptr_o`, `ecc_en_o` and `ecc_clr_o` within one cycle of the offending write. Threshold equality, pointer values 0, 9 and 12, and the soft reset are driven on purpose, because the errors most likely to slip through sit at those points.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int ADDR_W = 5;
  localparam int IRQ_W  = 12;
  localparam int PTR_W  = 4;
  localparam int LVL_W  = 8;

  typedef logic [ADDR_W-1:0] waddr_t;

  localparam waddr_t A_REV     = 5'd0;
  localparam waddr_t A_SYSCFG  = 5'd1;
  localparam waddr_t A_SYSSTAT = 5'd2;
  localparam waddr_t A_IRQST   = 5'd3;
  localparam waddr_t A_IRQEN   = 5'd4;
  localparam waddr_t A_PFCFG1  = 5'd5;
  localparam waddr_t A_PFCFG2  = 5'd6;
  localparam waddr_t A_PFCTL   = 5'd7;
  localparam waddr_t A_PFSTAT  = 5'd8;
  localparam waddr_t A_ECCCFG  = 5'd9;
  localparam waddr_t A_ECCCTL  = 5'd10;
  localparam waddr_t A_ECCSIZE = 5'd11;
  localparam waddr_t A_ECCRES  = 5'd12;

  localparam logic [IRQ_W-1:0] IRQ_MASK  = 12'hF03;
  localparam logic [31:0] SYSCFG_MASK    = 32'h0000_0019;
  localparam logic [31:0] PFCFG1_MASK    = 32'h7F8F_7FBF;
  localparam logic [31:0] PFCFG1_RST     = 32'h0000_4000;
  localparam logic [31:0] ECCSIZE_MASK   = 32'h3FCF_F1FF;
  localparam logic [31:0] ECCSIZE_RST    = 32'h3FCF_F000;
  localparam logic [7:0]  ECCCFG_MASK    = 8'h8F;
  localparam logic [LVL_W-1:0] PF_FULL   = 8'd64;
endpackage

// File: rtl/pe_irq.sv
module pe_irq
  import pe_pkg::*;
#(
  parameter int W = IRQ_W,
  parameter logic [W-1:0] MASK = IRQ_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         st_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] st_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] st_q, en_q, clr;

  assign clr = st_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= '0;
    end else if (soft_rst_i) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i & MASK;
      st_q <= (st_q & ~clr) | (evt_i & MASK);  // set wins over clear
    end
  end

  assign st_o  = st_q;
  assign en_o  = en_q;
  assign irq_o = |(st_q & en_q);

  // R2
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_i && !soft_rst_i && evt_i == '0) |=> ((st_q & $past(wdata_i)) == '0));

  // R1
  enabled_event_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((evt_i & MASK & en_q) != '0) && !soft_rst_i && !en_we_i) |=> irq_o);
endmodule

// File: rtl/pe_prefetch.sv
module pe_prefetch
  import pe_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             cfg1_we_i,
  input  logic             cfg2_we_i,
  input  logic             ctl_we_i,
  input  logic [31:0]      wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [31:0]      cfg1_o,
  output logic [CNT_W-1:0] cfg2_o,
  output logic             run_o,
  output logic [31:0]      status_o
);
  localparam int PAD_W = 16 - CNT_W;

  logic [31:0]       cfg1_q;
  logic [CNT_W-1:0]  cfg2_q;
  logic              run_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [6:0]        thr;
  logic              above;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= PFCFG1_RST;
      cfg2_q <= '0;
      run_q  <= 1'b0;
      lvl_q  <= '0;
    end else if (soft_rst_i) begin
      cfg1_q <= PFCFG1_RST;
      cfg2_q <= '0;
      run_q  <= 1'b0;
      lvl_q  <= '0;
    end else begin
      if (cfg1_we_i) cfg1_q <= wdata_i & PFCFG1_MASK;
      if (cfg2_we_i) cfg2_q <= wdata_i[CNT_W-1:0];
      if (ctl_we_i) begin
        run_q <= wdata_i[0];
        if (wdata_i[0]) lvl_q <= cfg1_q[0] ? PF_FULL : '0;
      end
    end
  end

  assign thr      = cfg1_q[14:8];
  assign above    = lvl_q > {1'b0, thr};
  assign status_o = {lvl_q, 7'b0, above, {PAD_W{1'b0}}, count_i};
  assign cfg1_o   = cfg1_q;
  assign cfg2_o   = cfg2_q;
  assign run_o    = run_q;

  // R4
  start_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && wdata_i[0] && !soft_rst_i) |=> (lvl_q == ($past(cfg1_q[0]) ? PF_FULL : '0)));

  // R4
  stop_keeps_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !wdata_i[0] && !soft_rst_i) |=> ($stable(lvl_q) && !run_q));
endmodule

// File: rtl/pe_ecc_ctl.sv
module pe_ecc_ctl
  import pe_pkg::*;
#(
  parameter int NUM_ECC = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             cfg_we_i,
  input  logic             ctl_we_i,
  input  logic             size_we_i,
  input  logic [31:0]      wdata_i,
  output logic [7:0]       cfg_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [31:0]      size_o,
  output logic             clr_o
);
  logic [7:0]       cfg_q;
  logic [PTR_W-1:0] ptr_q, ptr_new;
  logic [31:0]      size_q;
  logic             clr_q, ptr_bad, clr_req;

  assign ptr_new = wdata_i[PTR_W-1:0];
  assign ptr_bad = (ptr_new == '0) || (int'(ptr_new) > NUM_ECC);
  assign clr_req = soft_rst_i || (ctl_we_i && wdata_i[8]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      ptr_q  <= '0;
      size_q <= ECCSIZE_RST;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= clr_req;
      if (soft_rst_i) begin
        cfg_q  <= '0;
        ptr_q  <= '0;
        size_q <= ECCSIZE_RST;
      end else begin
        if (size_we_i) size_q <= wdata_i & ECCSIZE_MASK;
        if (cfg_we_i) cfg_q <= wdata_i[7:0] & ECCCFG_MASK;
        if (ctl_we_i) begin
          ptr_q <= ptr_bad ? '0 : ptr_new;
          if (ptr_bad) cfg_q[0] <= 1'b0;
        end
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign ptr_o  = ptr_q;
  assign size_o = size_q;
  assign clr_o  = clr_q;

  // R8
  bad_ptr_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ptr_bad) |=> (ptr_q == '0 && !cfg_q[0]));

  // R7
  clr_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req |=> clr_o);

  // R7
  clr_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o && !clr_req) |=> !clr_o);
endmodule

// File: rtl/pe_regbank.sv
module pe_regbank
  import pe_pkg::*;
#(
  parameter int NUM_ECC = 9,
  parameter int CNT_W   = 14,
  parameter logic [31:0] REV_ID = 32'h0000_0031
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 err_o,
  input  logic [IRQ_W-1:0]     irq_evt_i,
  output logic                 irq_o,
  input  logic [CNT_W-1:0]     pf_count_i,
  output logic                 pf_run_o,
  input  logic [NUM_ECC*32-1:0] ecc_res_i,
  output logic                 ecc_clr_o,
  output logic [PTR_W-1:0]     ecc_ptr_o,
  output logic                 ecc_en_o
);
  localparam int LAST_ADDR = int'(A_ECCRES) + NUM_ECC - 1;

  logic             soft_rst, wr_unknown, err_q;
  logic [31:0]      sys_q;
  logic [IRQ_W-1:0] irq_st, irq_en;
  logic [31:0]      pf_cfg1, pf_stat, ecc_size;
  logic [CNT_W-1:0] pf_cfg2;
  logic [7:0]       ecc_cfg;
  int               res_idx;

  function automatic logic wr_at(input waddr_t a);
    return we_i && (addr_i == a);
  endfunction

  assign soft_rst   = wr_at(A_SYSCFG) && wdata_i[1];
  assign wr_unknown = we_i && (int'(addr_i) > LAST_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_unknown;
      if (wr_at(A_SYSCFG)) sys_q <= wdata_i & SYSCFG_MASK;
    end
  end

  pe_irq #(.W(IRQ_W), .MASK(IRQ_MASK)) u_irq (
    .clk_i, .rst_ni, .soft_rst_i(soft_rst),
    .st_we_i(wr_at(A_IRQST)), .en_we_i(wr_at(A_IRQEN)),
    .wdata_i(wdata_i[IRQ_W-1:0]), .evt_i(irq_evt_i),
    .st_o(irq_st), .en_o(irq_en), .irq_o
  );

  pe_prefetch #(.CNT_W(CNT_W)) u_pf (
    .clk_i, .rst_ni, .soft_rst_i(soft_rst),
    .cfg1_we_i(wr_at(A_PFCFG1)), .cfg2_we_i(wr_at(A_PFCFG2)), .ctl_we_i(wr_at(A_PFCTL)),
    .wdata_i, .count_i(pf_count_i),
    .cfg1_o(pf_cfg1), .cfg2_o(pf_cfg2), .run_o(pf_run_o), .status_o(pf_stat)
  );

  pe_ecc_ctl #(.NUM_ECC(NUM_ECC)) u_ecc (
    .clk_i, .rst_ni, .soft_rst_i(soft_rst),
    .cfg_we_i(wr_at(A_ECCCFG)), .ctl_we_i(wr_at(A_ECCCTL)), .size_we_i(wr_at(A_ECCSIZE)),
    .wdata_i, .cfg_o(ecc_cfg), .ptr_o(ecc_ptr_o), .size_o(ecc_size), .clr_o(ecc_clr_o)
  );

  assign ecc_en_o = ecc_cfg[0];
  assign err_o    = err_q;
  assign res_idx  = int'(addr_i) - int'(A_ECCRES);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_REV:     rdata_o = REV_ID;
      A_SYSCFG:  rdata_o = sys_q;
      A_SYSSTAT: rdata_o = 32'd1;
      A_IRQST:   rdata_o = 32'(irq_st);
      A_IRQEN:   rdata_o = 32'(irq_en);
      A_PFCFG1:  rdata_o = pf_cfg1;
      A_PFCFG2:  rdata_o = 32'(pf_cfg2);
      A_PFCTL:   rdata_o = {31'b0, pf_run_o};
      A_PFSTAT:  rdata_o = pf_stat;
      A_ECCCFG:  rdata_o = 32'(ecc_cfg);
      A_ECCCTL:  rdata_o = 32'(ecc_ptr_o);
      A_ECCSIZE: rdata_o = ecc_size;
      default:
        if (res_idx >= 0 && res_idx < NUM_ECC) rdata_o = ecc_res_i[res_idx*32 +: 32];
    endcase
  end

  // R11
  unknown_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_unknown |=> err_o);

  // R10
  ro_write_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_REV || addr_i == A_PFSTAT || addr_i == A_ECCRES)) |=> !err_o);

  // R3
  soft_reset_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (pf_cfg1 == PFCFG1_RST && ecc_size == ECCSIZE_RST && irq_en == '0 && !pf_run_o));
endmodule

// File: tb/pe_regbank_tb.sv
`timescale 1ns/1ps
module pe_regbank_tb;
  typedef struct packed {
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [31:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd4,  32'hFFFF_FFFF, 5'd4,  32'h0000_0F03, 4'd1},  // R1 enable mask
    '{1'b1, 5'd5,  32'hFFFF_FFFF, 5'd5,  32'h7F8F_7FBF, 4'd6},  // R6 cfg1 mask
    '{1'b1, 5'd6,  32'hFFFF_FFFF, 5'd6,  32'h0000_3FFF, 4'd6},  // R6 cfg2 width
    '{1'b1, 5'd11, 32'hFFFF_FFFF, 5'd11, 32'h3FCF_F1FF, 4'd9},  // R9 size mask
    '{1'b1, 5'd9,  32'hFFFF_FFFF, 5'd9,  32'h0000_008F, 4'd9},  // R9 cfg mask
    '{1'b1, 5'd10, 32'h0000_0005, 5'd10, 32'h0000_0005, 4'd8},  // R8 legal ptr
    '{1'b1, 5'd10, 32'h0000_000C, 5'd10, 32'h0000_0000, 4'd8},  // R8 ptr 12
    '{1'b0, 5'd0,  32'h0,         5'd9,  32'h0000_008E, 4'd8},  // R8 enable dropped
    '{1'b1, 5'd10, 32'h0000_0009, 5'd10, 32'h0000_0009, 4'd8},  // R8 ptr 9 legal
    '{1'b1, 5'd0,  32'h1234_5678, 5'd0,  32'h0000_0031, 4'd10}, // R10 identity
    '{1'b1, 5'd2,  32'h0,         5'd2,  32'h0000_0001, 4'd10}, // R10 sys status
    '{1'b1, 5'd8,  32'hFFFF_FFFF, 5'd8,  32'h0000_0ABC, 4'd10}, // R10 pf status RO
    '{1'b1, 5'd5,  32'h0000_1001, 5'd5,  32'h0000_1001, 4'd6},  // R6
    '{1'b1, 5'd7,  32'h0000_0001, 5'd8,  32'h4001_0ABC, 4'd4},  // R4 dir=1 -> 64
    '{1'b1, 5'd5,  32'h0000_4000, 5'd8,  32'h4000_0ABC, 4'd5},  // R5 equal thr
    '{1'b1, 5'd7,  32'h0000_0000, 5'd7,  32'h0000_0000, 4'd4},  // R4 stop
    '{1'b0, 5'd0,  32'h0,         5'd8,  32'h4000_0ABC, 4'd4},  // R4 level kept
    '{1'b1, 5'd5,  32'h0000_3F00, 5'd8,  32'h4001_0ABC, 4'd5},  // R5 above thr
    '{1'b1, 5'd7,  32'h0000_0001, 5'd8,  32'h0000_0ABC, 4'd4},  // R4 dir=0 -> 0
    '{1'b1, 5'd12, 32'hFFFF_FFFF, 5'd12, 32'hE000_0000, 4'd10}, // R10 result RO
    '{1'b0, 5'd0,  32'h0,         5'd20, 32'hE000_0008, 4'd11}, // R11 last result
    '{1'b0, 5'd0,  32'h0,         5'd25, 32'h0000_0000, 4'd11}  // R11 unmapped
  };

  logic clk = 0, rst_n = 0, we = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err, irq, pf_run, ecc_clr, ecc_en;
  logic [11:0] evt = '0;
  logic [13:0] pf_count = 14'h0ABC;
  logic [9*32-1:0] ecc_res;
  logic [3:0] ecc_ptr;
  int checks = 0, errors = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  for (genvar k = 0; k < 9; k++) begin : g_res
    assign ecc_res[k*32 +: 32] = 32'hE000_0000 + k;
  end

  pe_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .irq_evt_i(evt), .irq_o(irq),
    .pf_count_i(pf_count), .pf_run_o(pf_run), .ecc_res_i(ecc_res),
    .ecc_clr_o(ecc_clr), .ecc_ptr_o(ecc_ptr), .ecc_en_o(ecc_en)
  );

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", rq, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(input string rq, input logic [4:0] a, input logic [31:0] exp);
    addr = a; #1; chk(rq, rdata, exp);
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state: R6 R9 R1 R8
    rd_chk("R6", 5'd5, 32'h0000_4000);
    rd_chk("R6", 5'd6, 32'h0);
    rd_chk("R9", 5'd11, 32'h3FCF_F000);
    rd_chk("R9", 5'd9, 32'h0);
    rd_chk("R1", 5'd4, 32'h0);
    rd_chk("R8", 5'd10, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);
    chk("R7", {31'b0, ecc_clr}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].wa, VEC[i].wd);
      else @(negedge clk);
      rd_chk($sformatf("R%0d", VEC[i].rq), VEC[i].ra, VEC[i].ex);
    end

    // R2 / R1 interrupt behaviour
    wr(5'd4, 32'h0000_0003);
    pulse(12'h001);
    rd_chk("R2", 5'd3, 32'h001);
    chk("R1", {31'b0, irq}, 32'h1);
    pulse(12'h104);
    rd_chk("R2", 5'd3, 32'h101);
    wr(5'd3, 32'h0000_0001);
    rd_chk("R2", 5'd3, 32'h100);
    chk("R2", {31'b0, irq}, 32'h0);
    wr(5'd4, 32'h0000_0100);
    chk("R1", {31'b0, irq}, 32'h1);
    wr(5'd3, 32'h0000_0100);
    chk("R2", {31'b0, irq}, 32'h0);

    // R9 / R8 enable and pointer outputs
    wr(5'd9, 32'h0000_0001);
    chk("R9", {31'b0, ecc_en}, 32'h1);
    wr(5'd10, 32'h0000_0000);
    chk("R8", {31'b0, ecc_en}, 32'h0);
    chk("R8", {28'b0, ecc_ptr}, 32'h0);

    // R7 clear strobe
    wr(5'd10, 32'h0000_0103);
    chk("R7", {31'b0, ecc_clr}, 32'h1);
    chk("R8", {28'b0, ecc_ptr}, 32'h3);
    @(negedge clk);
    chk("R7", {31'b0, ecc_clr}, 32'h0);

    // R11 / R10 error flag
    wr(5'd25, 32'hDEAD_BEEF);
    chk("R11", {31'b0, err}, 32'h1);
    @(negedge clk);
    chk("R11", {31'b0, err}, 32'h0);
    wr(5'd8, 32'h1);
    chk("R10", {31'b0, err}, 32'h0);

    // R3 soft reset
    wr(5'd1, 32'h0000_001B);
    chk("R7", {31'b0, ecc_clr}, 32'h1);
    rd_chk("R3", 5'd1, 32'h0000_0019);
    rd_chk("R3", 5'd5, 32'h0000_4000);
    rd_chk("R3", 5'd11, 32'h3FCF_F000);
    rd_chk("R3", 5'd4, 32'h0);
    rd_chk("R3", 5'd8, 32'h0000_0ABC);
    chk("R3", {31'b0, pf_run}, 32'h0);
    chk("R3", {28'b0, ecc_ptr}, 32'h0);

    done = 1;
    finish_run();
  end
endmodule